// File: doc/BRIEF.md
# Register-Mapped SPI Master with Transmit and Receive Queues

This block is an SPI bus master that a processor runs through a small 32-bit register window. Software sets the frame length, the serial clock divisor and the clock polarity and phase in two control words, then pushes words into a 16-entry transmit queue by writing the data register. While the port is enabled, a shift engine takes one word at a time and clocks it out MSB first. The word it collects from MISO during the same frame goes into a 16-entry receive queue, and software reads it back from the same data register.

Chip select is not tied to frames. Software holds it through a separate register, so one select window can cover any number of frames. Three level-sensitive interrupt lines report a transmit queue running low, a receive queue filling up, and received data left unread while the bus sits idle. A status word shows both queue levels and two flags.

The serial clock runs at the functional clock divided by a programmed divisor. All programmed counts are stored as the value minus one.

Top module: `spi_fifo_master`

## Requirements
- R1: After reset the status word (offset 0x08) reads 0x0000_0004, cs_n is high, sclk is low, all three interrupt lines are low, and a read of the data register returns 0.
- R2: A write to offset 0x10 queues bits 15:0 for transmission. Each frame shifts N bits out on mosi MSB first, where N is control-0 bits 3:0 plus one. Each frame places exactly one N-bit word, MSB first, into the receive queue, and reads of offset 0x10 return these words in arrival order.
- R3: Control-1 bit 3 (polarity) sets the idle level of sclk. Control-1 bit 4 (phase) selects the sampling edge. With phase 0, mosi is valid before the first edge, both sides sample on the leading edge and change data on the trailing edge. With phase 1, data changes on the leading edge and is sampled on the trailing edge.
- R4: The sclk period is the control-0 bits 19:8 field plus one functional clocks. A field of 0 gives a period of 2. The low phase is the divisor divided by two, rounded down, and the high phase is the rest.
- R5: Status bit 2 is set when the transmit queue is not full, and bit 3 is set when the receive queue is not empty. Bits 11:8 give the transmit level and bits 15:12 the receive level, each modulo 16, so a full queue reads level 0.
- R6: A write to a full transmit queue is dropped. A read of an empty receive queue returns 0 and changes nothing.
- R7: irq_tx is high while control-1 bit 1 is set and the transmit level is at most the control-1 bits 9:6 field plus one.
- R8: irq_rx is high while control-1 bit 0 is set and the receive level is at least the control-1 bits 13:10 field plus one.
- R9: irq_tmo is high while control-1 bit 19 is set, the receive queue is non-empty, and no frame has completed for at least the number of functional clocks held at offset 0x14 (reset value 64).
- R10: Frames start only while control-0 bit 7 is set. A write to offset 0x00 with bit 7 clear empties both queues and stops any frame in progress.
- R11: With bit 0 of offset 0x18 set, cs_n follows bit 1 of that register. With bit 0 clear, cs_n stays high.
- R12: While enabled, frames follow one another until the transmit queue is empty. The queue then shows level 0 with the not-full flag set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Functional clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_sel | input | 1 | Register access strobe for this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the same cycle as the strobe |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| cs_n | output | 1 | Chip select, software driven |
| irq_tx | output | 1 | Transmit queue low |
| irq_rx | output | 1 | Receive queue reached its threshold |
| irq_tmo | output | 1 | Unread data idle too long |

## Verification
The queue counters and the frame engine are the two stores that can go wrong. A bad counter shows at once in the status word and on the threshold interrupts, because both are combinational from the counts. A shift engine that takes a wrong edge or miscounts bits corrupts the first received word and the slave's captured bits within one frame. It also moves the sclk edge spacing away from the divisor in the very next period. A stuck engine leaves the transmit level frozen and never returns sclk to its idle level, and the polling loops catch that within a few thousand cycles.

// File: rtl/sfm_pkg.sv
package sfm_pkg;

  localparam logic [7:0] A_CTL0 = 8'h00;
  localparam logic [7:0] A_CTL1 = 8'h04;
  localparam logic [7:0] A_STAT = 8'h08;
  localparam logic [7:0] A_DATA = 8'h10;
  localparam logic [7:0] A_TMO  = 8'h14;
  localparam logic [7:0] A_CSEL = 8'h18;

  typedef enum logic {SH_IDLE, SH_RUN} sh_state_e;

  // divisor field is stored minus one; periods below two clocks are lifted to two
  function automatic logic [12:0] sclk_div(input logic [11:0] fld);
    logic [12:0] d;
    d = {1'b0, fld} + 13'd1;
    if (d < 13'd2) d = 13'd2;
    return d;
  endfunction

  // clocks spent before a leading edge (low phase for polarity 0)
  function automatic logic [12:0] lead_half(input logic [12:0] d);
    return d >> 1;
  endfunction

  // clocks spent before a trailing edge
  function automatic logic [12:0] trail_half(input logic [12:0] d);
    return d - (d >> 1);
  endfunction

  function automatic logic [4:0] frame_bits(input logic [3:0] fld);
    return {1'b0, fld} + 5'd1;
  endfunction

  function automatic logic [4:0] thresh(input logic [3:0] fld);
    return {1'b0, fld} + 5'd1;
  endfunction

endpackage

// File: rtl/sfm_fifo.sv
module sfm_fifo #(
  parameter int DW    = 16,
  parameter int DEPTH = 16
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         flush,
  input  logic                         push,
  input  logic [DW-1:0]                din,
  input  logic                         pop,
  output logic [DW-1:0]                dout,
  output logic [$clog2(DEPTH):0]       count,
  output logic                         full,
  output logic                         empty
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = AW + 1;

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic          push_ok, pop_ok;

  assign full    = (count == CW'(DEPTH));
  assign empty   = (count == '0);
  assign push_ok = push && !full;
  assign pop_ok  = pop && !empty;
  assign dout    = mem[rp];

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (push_ok) mem[wp] <= din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp <= '0; rp <= '0; count <= '0;
    end else if (flush) begin
      wp <= '0; rp <= '0; count <= '0;
    end else begin
      if (push_ok) wp <= nxt(wp);
      if (pop_ok)  rp <= nxt(rp);
      case ({push_ok, pop_ok})
        2'b10:   count <= count + CW'(1);
        2'b01:   count <= count - CW'(1);
        default: count <= count;
      endcase
    end
  end
endmodule

// File: rtl/sfm_shifter.sv
module sfm_shifter import sfm_pkg::*; #(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          enable,
  input  logic          abort,
  input  logic          cpol,
  input  logic          cpha,
  input  logic [4:0]    nbits,
  input  logic [12:0]   div,
  input  logic          tx_valid,
  input  logic [DW-1:0] tx_word,
  output logic          tx_take,
  output logic [DW-1:0] rx_word,
  output logic          rx_done,
  output logic          busy,
  output logic          sclk,
  output logic          mosi,
  input  logic          miso
);
  localparam int EW = $clog2(2 * DW) + 1;

  sh_state_e     state;
  logic [12:0]   cnt;
  logic [EW-1:0] edge_n;
  logic          sck_q, mosi_q;
  logic [DW-1:0] tx_sh, rx_sh, rx_next, aligned;
  logic          tick, leading, sample_now, launch_now, last;
  logic [EW-1:0] last_idx;

  assign aligned    = tx_word << (DW - int'(nbits));
  assign tx_take    = (state == SH_IDLE) && enable && tx_valid && !abort;
  assign tick       = (state == SH_RUN) && (cnt == 13'd1);
  assign leading    = !edge_n[0];
  assign last_idx   = EW'({nbits, 1'b0}) - EW'(1);
  assign last       = (edge_n == last_idx);
  assign sample_now = tick && (leading ^ cpha);
  assign launch_now = tick && !(leading ^ cpha);
  assign rx_next    = {rx_sh[DW-2:0], miso};
  assign busy       = (state == SH_RUN);
  assign sclk       = sck_q ^ cpol;
  assign mosi       = mosi_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= SH_IDLE;
      cnt     <= '0;
      edge_n  <= '0;
      sck_q   <= 1'b0;
      mosi_q  <= 1'b0;
      tx_sh   <= '0;
      rx_sh   <= '0;
      rx_word <= '0;
      rx_done <= 1'b0;
    end else begin
      rx_done <= 1'b0;
      if (abort) begin
        state  <= SH_IDLE;
        cnt    <= '0;
        edge_n <= '0;
        sck_q  <= 1'b0;
      end else if (state == SH_IDLE) begin
        if (tx_take) begin
          state  <= SH_RUN;
          edge_n <= '0;
          sck_q  <= 1'b0;
          cnt    <= lead_half(div);
          rx_sh  <= '0;
          if (!cpha) begin
            mosi_q <= aligned[DW-1];
            tx_sh  <= aligned << 1;
          end else begin
            tx_sh  <= aligned;
          end
        end
      end else if (tick) begin
        sck_q  <= ~sck_q;
        edge_n <= edge_n + EW'(1);
        cnt    <= leading ? trail_half(div) : lead_half(div);
        if (sample_now) rx_sh <= rx_next;
        if (launch_now && !last) begin
          mosi_q <= tx_sh[DW-1];
          tx_sh  <= tx_sh << 1;
        end
        if (last) begin
          state   <= SH_IDLE;
          rx_word <= sample_now ? rx_next : rx_sh;
          rx_done <= 1'b1;
        end
      end else begin
        cnt <= cnt - 13'd1;
      end
    end
  end
endmodule

// File: rtl/spi_fifo_master.sv
module spi_fifo_master import sfm_pkg::*; #(
  parameter int               DEPTH   = 16,
  parameter int               DW      = 16,
  parameter int               TMO_W   = 16,
  parameter logic [TMO_W-1:0] TMO_RST = TMO_W'(64)
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_sel,
  input  logic        bus_wr,
  input  logic [7:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic        sclk,
  output logic        mosi,
  input  logic        miso,
  output logic        cs_n,
  output logic        irq_tx,
  output logic        irq_rx,
  output logic        irq_tmo
);
  localparam int CW = $clog2(DEPTH) + 1;

  logic [31:0]      c0_q, c1_q;
  logic [TMO_W-1:0] tmo_lim_q, idle_cnt;
  logic [1:0]       csel_q;

  // named events for the checker
  logic wr_en, rd_en, flush, tx_push, tx_push_blocked, rx_pop, tx_take, rx_done, sh_busy;
  logic [CW-1:0] tx_cnt, rx_cnt;
  logic          tx_full, tx_empty, rx_full, rx_empty;
  logic [DW-1:0] tx_head, rx_head, rx_word;
  logic [31:0]   status, tx_cnt32, rx_cnt32;
  logic [3:0]    tx_lvl4, rx_lvl4;

  assign wr_en           = bus_sel && bus_wr;
  assign rd_en           = bus_sel && !bus_wr;
  assign flush           = wr_en && (bus_addr == A_CTL0) && !bus_wdata[7];
  assign tx_push         = wr_en && (bus_addr == A_DATA);
  assign tx_push_blocked = tx_push && tx_full;
  assign rx_pop          = rd_en && (bus_addr == A_DATA);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      c0_q      <= '0;
      c1_q      <= '0;
      tmo_lim_q <= TMO_RST;
      csel_q    <= '0;
    end else if (wr_en) begin
      case (bus_addr)
        A_CTL0:  c0_q      <= bus_wdata;
        A_CTL1:  c1_q      <= bus_wdata;
        A_TMO:   tmo_lim_q <= bus_wdata[TMO_W-1:0];
        A_CSEL:  csel_q    <= bus_wdata[1:0];
        default: ;
      endcase
    end
  end

  sfm_fifo #(.DW(DW), .DEPTH(DEPTH)) u_txq (
    .clk(clk), .rst_n(rst_n), .flush(flush),
    .push(tx_push), .din(bus_wdata[DW-1:0]),
    .pop(tx_take), .dout(tx_head),
    .count(tx_cnt), .full(tx_full), .empty(tx_empty)
  );

  sfm_fifo #(.DW(DW), .DEPTH(DEPTH)) u_rxq (
    .clk(clk), .rst_n(rst_n), .flush(flush),
    .push(rx_done), .din(rx_word),
    .pop(rx_pop), .dout(rx_head),
    .count(rx_cnt), .full(rx_full), .empty(rx_empty)
  );

  sfm_shifter #(.DW(DW)) u_shift (
    .clk(clk), .rst_n(rst_n),
    .enable(c0_q[7]), .abort(flush),
    .cpol(c1_q[3]), .cpha(c1_q[4]),
    .nbits(frame_bits(c0_q[3:0])), .div(sclk_div(c0_q[19:8])),
    .tx_valid(!tx_empty), .tx_word(tx_head), .tx_take(tx_take),
    .rx_word(rx_word), .rx_done(rx_done), .busy(sh_busy),
    .sclk(sclk), .mosi(mosi), .miso(miso)
  );

  // idle timer: counts while unread data waits, restarts on each finished frame
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                 idle_cnt <= '0;
    else if (flush || rx_empty || rx_done)      idle_cnt <= '0;
    else if (idle_cnt != {TMO_W{1'b1}})         idle_cnt <= idle_cnt + TMO_W'(1);
  end

  assign tx_cnt32 = 32'(tx_cnt);
  assign rx_cnt32 = 32'(rx_cnt);
  assign tx_lvl4  = tx_cnt32[3:0];
  assign rx_lvl4  = rx_cnt32[3:0];

  assign irq_tx  = c1_q[1]  && (tx_cnt32 <= 32'(thresh(c1_q[9:6])));
  assign irq_rx  = c1_q[0]  && (rx_cnt32 >= 32'(thresh(c1_q[13:10])));
  assign irq_tmo = c1_q[19] && !rx_empty && (idle_cnt >= tmo_lim_q);

  assign cs_n   = csel_q[0] ? csel_q[1] : 1'b1;
  assign status = {16'h0, rx_lvl4, tx_lvl4, 4'h0, !rx_empty, !tx_full, 2'b00};

  always_comb begin
    case (bus_addr)
      A_CTL0:  bus_rdata = c0_q;
      A_CTL1:  bus_rdata = c1_q;
      A_STAT:  bus_rdata = status;
      A_DATA:  bus_rdata = rx_empty ? 32'h0 : 32'(rx_head);
      A_TMO:   bus_rdata = 32'(tmo_lim_q);
      A_CSEL:  bus_rdata = {30'h0, csel_q};
      default: bus_rdata = 32'h0;
    endcase
  end
endmodule

// File: rtl/sfm_checker.sv
module sfm_checker #(
  parameter int DEPTH = 16
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   flush,
  input logic                   tx_push_blocked,
  input logic                   tx_take,
  input logic [$clog2(DEPTH):0] tx_cnt,
  input logic [$clog2(DEPTH):0] rx_cnt,
  input logic                   sh_busy,
  input logic                   rx_done,
  input logic                   irq_tmo
);
  localparam int CW = $clog2(DEPTH) + 1;

  a_r5_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_cnt <= CW'(DEPTH)) && (rx_cnt <= CW'(DEPTH)));

  a_r6_full_push_dropped: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_push_blocked && !tx_take && !flush) |=> (tx_cnt == CW'(DEPTH)));

  a_r10_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (tx_cnt == '0) && (rx_cnt == '0) && !sh_busy);

  a_r12_start_needs_data: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sh_busy) |-> ($past(tx_cnt) != '0));

  a_r2_rx_grows_on_frame: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_done |=> (rx_cnt <= $past(rx_cnt)));

  a_r9_tmo_needs_data: assert property (@(posedge clk) disable iff (!rst_n)
    irq_tmo |-> (rx_cnt != '0));
endmodule

bind spi_fifo_master sfm_checker #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .flush(flush),
  .tx_push_blocked(tx_push_blocked), .tx_take(tx_take),
  .tx_cnt(tx_cnt), .rx_cnt(rx_cnt), .sh_busy(sh_busy),
  .rx_done(rx_done), .irq_tmo(irq_tmo)
);

// File: tb/tb_spi_fifo_master.sv
module tb_spi_fifo_master;
  localparam int PERIOD = 10;

  logic clk = 0, rst_n = 0;
  logic bus_sel = 0, bus_wr = 0;
  logic [7:0]  bus_addr = 0;
  logic [31:0] bus_wdata = 0, bus_rdata;
  logic sclk, mosi, miso = 0, cs_n, irq_tx, irq_rx, irq_tmo;

  spi_fifo_master dut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .sclk(sclk), .mosi(mosi), .miso(miso), .cs_n(cs_n),
    .irq_tx(irq_tx), .irq_rx(irq_rx), .irq_tmo(irq_tmo)
  );

  always #(PERIOD/2) clk = ~clk;

  int checks = 0, fails = 0;
  bit done = 0;

  // slave model state
  logic cur_cpol = 0, cur_cpha = 0;
  int   cur_nb = 8, exp_div = 2;
  logic cap [0:1023];
  int   ncap = 0, lidx = 0, lcount = 0, per_bad = 0;
  int   cyc = 0, last_lead = 0;

  function automatic logic sbit(input int k);
    return logic'((k ^ (k >> 2) ^ (k >> 3)) & 1);
  endfunction

  function automatic logic [15:0] txw(input int j, input int n);
    logic [15:0] m;
    m = 16'((32'h1 << n) - 1);
    return 16'(j * 37 + 11 + n * 3) & m;
  endfunction

  function automatic logic [15:0] rxw(input int j, input int n);
    logic [15:0] w = 0;
    for (int i = 0; i < n; i++) w = {w[14:0], sbit(j * n + i)};
    return w;
  endfunction

  always @(posedge clk) cyc++;

  always @(negedge cs_n) begin
    ncap = 0; lcount = 0;
    if (!cur_cpha) begin miso = sbit(0); lidx = 1; end
    else lidx = 0;
  end

  always @(sclk) begin
    if (cs_n === 1'b0) begin
      logic lead;
      lead = (sclk != cur_cpol);
      if (lead) begin
        if ((lcount % cur_nb) != 0 && (cyc - last_lead) != exp_div) per_bad++;
        last_lead = cyc;
        lcount++;
      end
      if (lead ^ cur_cpha) begin
        if (ncap < 1024) cap[ncap] = mosi;
        ncap++;
      end else begin
        miso = sbit(lidx);
        lidx++;
      end
    end
  end

  task automatic chk(input string req, input logic ok, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 0; bus_wr = 0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_sel = 1; bus_wr = 0; bus_addr = a;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_sel = 0;
  endtask

  // poll until n words received and transmit queue drained
  task automatic wait_rx(input int n);
    logic [31:0] s;
    for (int it = 0; it < 6000; it++) begin
      rd(8'h08, s);
      if (s[15:12] == 4'(n) && s[3] == (n > 0) && s[11:8] == 4'h0 && s[2]) return;
    end
  endtask

  task automatic run_xfer(input int po, input int ph, input int nb, input int divf, input int nw);
    logic [31:0] d;
    int bad_rx = 0, bad_tx = 0;
    wr(8'h00, 0);
    wr(8'h18, 3);
    cur_cpol = logic'(po); cur_cpha = logic'(ph); cur_nb = nb;
    exp_div = (divf + 1 < 2) ? 2 : divf + 1;
    wr(8'h04, (ph << 4) | (po << 3));
    wr(8'h00, (divf << 8) | (nb - 1));
    for (int j = 0; j < nw; j++) wr(8'h10, 32'(txw(j, nb)));
    per_bad = 0;
    wr(8'h18, 1);
    wr(8'h00, (divf << 8) | (nb - 1) | 32'h80);
    wait_rx(nw);
    chk("R3 idle level", sclk == logic'(po), int'(sclk), po);
    wr(8'h18, 3);
    for (int j = 0; j < nw; j++) begin
      rd(8'h10, d);
      if (d[15:0] != rxw(j, nb)) bad_rx++;
    end
    chk("R2/R3 rx words", bad_rx == 0, bad_rx, 0);
    for (int j = 0; j < nw; j++)
      for (int i = 0; i < nb; i++)
        if (cap[j * nb + i] !== txw(j, nb)[nb - 1 - i]) bad_tx++;
    chk("R2/R3 mosi bits", bad_tx == 0 && ncap == nw * nb, bad_tx, 0);
    chk("R4 sclk period", per_bad == 0, per_bad, 0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R1 reset state
    rd(8'h08, d);
    chk("R1 status", d == 32'h4, d, 4);
    chk("R1 pins", cs_n == 1 && sclk == 0 && !irq_tx && !irq_rx && !irq_tmo,
        {cs_n, sclk, irq_tx, irq_rx, irq_tmo}, 5'b10000);
    rd(8'h10, d);
    chk("R1/R6 empty read", d == 0, d, 0);

    // R11 chip select
    for (int v = 0; v < 4; v++) begin
      wr(8'h18, v);
      chk("R11 cs_n", cs_n == ((v & 1) ? logic'(v >> 1) : 1'b1), cs_n, (v & 1) ? (v >> 1) : 1);
    end

    // R2 R3 R4 R12 sweep of modes, frame sizes and divisors
    for (int po = 0; po < 2; po++)
      for (int ph = 0; ph < 2; ph++)
        for (int si = 0; si < 4; si++)
          for (int di = 0; di < 3; di++)
            run_xfer(po, ph, (si == 0) ? 4 : (si == 1) ? 8 : (si == 2) ? 13 : 16,
                     (di == 0) ? 0 : (di == 1) ? 1 : 4, 3);

    // R6 R5 R12 full transmit queue
    wr(8'h00, 0); wr(8'h04, 0); wr(8'h18, 3);
    cur_cpol = 0; cur_cpha = 0; cur_nb = 8; exp_div = 2;
    wr(8'h00, 32'h0107);
    for (int j = 0; j < 17; j++) wr(8'h10, j + 1);
    rd(8'h08, d);
    chk("R5/R6 full status", d == 32'h0, d, 0);
    wr(8'h18, 1);
    wr(8'h00, 32'h0187);
    wait_rx(16);
    rd(8'h08, d);
    chk("R5/R12 rx full tx empty", d == 32'h0000_000C, d, 32'hC);
    chk("R6 dropped word not sent", ncap == 128, ncap, 128);
    begin
      int bad = 0;
      for (int j = 0; j < 16; j++) begin
        rd(8'h10, d);
        if (d[15:0] != rxw(j, 8)) bad++;
      end
      chk("R2 sixteen words", bad == 0, bad, 0);
    end
    rd(8'h10, d);
    chk("R6 read when empty", d == 0, d, 0);
    rd(8'h08, d);
    chk("R6 status after empty read", d == 32'h4, d, 4);
    wr(8'h18, 3);

    // R7 transmit threshold interrupt (threshold 3)
    wr(8'h00, 0);
    wr(8'h04, (1 << 1) | (2 << 6));
    for (int k = 0; k < 6; k++) begin
      chk("R7 irq_tx level", irq_tx == (k <= 3), irq_tx, k <= 3);
      wr(8'h10, k);
    end
    wr(8'h00, 0);
    wr(8'h04, (2 << 6));
    chk("R7 irq_tx disabled", irq_tx == 0, irq_tx, 0);

    // R10 no shifting while disabled, flush on disable write
    for (int j = 0; j < 3; j++) wr(8'h10, j);
    repeat (40) @(negedge clk);
    rd(8'h08, d);
    chk("R10 held while disabled", d == 32'h0304, d, 32'h304);
    wr(8'h00, 32'h0107);
    rd(8'h08, d);
    chk("R10 flush", d == 32'h4, d, 4);

    // R8 receive threshold interrupt (threshold 2)
    wr(8'h04, 1 | (1 << 10));
    wr(8'h18, 1);
    wr(8'h00, 32'h0187);
    wr(8'h10, 5);
    wait_rx(1);
    chk("R8 irq_rx below", irq_rx == 0, irq_rx, 0);
    wr(8'h10, 6);
    wait_rx(2);
    chk("R8 irq_rx at threshold", irq_rx == 1, irq_rx, 1);
    rd(8'h10, d);
    chk("R8 irq_rx after pop", irq_rx == 0, irq_rx, 0);

    // R9 idle timeout interrupt (limit 20)
    wr(8'h00, 0);
    wr(8'h04, 1 << 19);
    wr(8'h14, 20);
    wr(8'h00, 32'h0187);
    wr(8'h10, 9);
    wait_rx(1);
    chk("R9 irq_tmo early", irq_tmo == 0, irq_tmo, 0);
    repeat (30) @(negedge clk);
    chk("R9 irq_tmo after limit", irq_tmo == 1, irq_tmo, 1);
    rd(8'h10, d);
    chk("R9 irq_tmo after pop", irq_tmo == 0, irq_tmo, 0);
    wr(8'h18, 3);

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule